// File: doc/BRIEF.md
# Sampling Clock Phase-Frequency Lock

This block runs the local sampling clock of a measuring terminal that must sample in step with peer terminals and with the power system. The clock is a 32-bit phase accumulator. Each clock cycle it adds an increment, and it emits a one-cycle sample strobe every time the addition carries out of the top bit. The increment is trimmed by a proportional-integral loop. The loop's error is the sum of a grid frequency-deviation estimate and a phase-deviation estimate taken against the remote clocks. The loop acts only on cycles that carry a new estimate, which are marked by an update strobe.

Two phase-deviation estimates arrive at the block: one built from the channel timing exchange and one derived from current phasors. A select input names the estimate that is more accurate at the moment, and only that one drives the loop and the lock detector. Tracking needs enough current to work. When the current magnitude is not above a programmable threshold, the block stops tracking: the increment goes back to the nominal value, the integrator is cleared and lock is dropped. Each loop update can move the increment by no more than a programmable clamp, so only fine corrections are applied. The lock flag reports that the residual phase error has stayed below a programmable bound, normally set to the count equal to 26 µs, for 16 updates in a row.

Top module: `sclk_lock_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `cur_inc` equals `nom_inc`, `sample_strobe` is 0 and `locked` is 0. The accumulator and the integrator start at zero.
- R2: On every clock edge out of reset, the accumulator adds `cur_inc`, taken modulo 2^32. `sample_strobe` is 1 in the following cycle exactly when that addition carried out of bit 31.
- R3: Tracking is active only when `cur_mag > cur_thresh` (unsigned). When it is not active, the next cycle shows `cur_inc == nom_inc`, `locked == 0`, a cleared integrator and a cleared good-update count. This holds whatever `upd_valid` does.
- R4: On a tracking cycle with `upd_valid=1`, let e = freq_err + ph. The integrator becomes I = sat24(I + e), a 24-bit two's-complement value that saturates. The correction is (e >>> 2) + (I >>> 6), using arithmetic shifts, and the clamped correction is added to `cur_inc` modulo 2^32.
- R5: The phase term ph is `ph_err_phsr` when `use_phsr=1` and `ph_err_chan` when `use_phsr=0`. The same ph feeds both the loop and the lock detector.
- R6: The correction added per update is limited to the range [-step_clamp, +step_clamp].
- R7: `locked` rises in the cycle after the 16th consecutive tracking update with |ph| < `lock_thr` (strict compare).
- R8: `locked` falls in the cycle after the first tracking update with |ph| >= `lock_thr`. That update also restarts the consecutive count.
- R9: While tracking with `upd_valid=0`, `cur_inc`, `locked` and the integrator stay unchanged, whatever the values on the error inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | New deviation estimates present this cycle |
| freq_err | input | 16 | Signed frequency deviation (grid minus clock) |
| ph_err_chan | input | 16 | Signed phase deviation from channel exchange |
| ph_err_phsr | input | 16 | Signed phase deviation from phasors |
| use_phsr | input | 1 | 1 selects the phasor phase estimate |
| cur_mag | input | 16 | Largest terminal current magnitude |
| cur_thresh | input | 16 | Tracking enable threshold (0.125 pu) |
| nom_inc | input | 32 | Increment for nominal frequency |
| step_clamp | input | 16 | Largest change of the increment per update |
| lock_thr | input | 16 | Phase error bound for lock (26 µs) |
| sample_strobe | output | 1 | One-cycle pulse on accumulator wrap |
| cur_inc | output | 32 | Increment in use |
| locked | output | 1 | Phase lock indication |

## Verification
The assertions are checked on every cycle. They cover the wrap-to-strobe relation, the return to nominal and the drop of lock whenever current is low, the bound on each increment change, the freezing of increment and lock between updates, and the loss of lock on an out-of-bound phase error. The exact PI arithmetic, integrator saturation, the choice between the two phase estimates and the sixteen-update lock build-up cannot be checked that way. They show up only in the bench scenarios, where a behavioural model tracks the integrator across long update sequences with positive, negative and clamped errors.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    localparam int PKG_ACC_W   = 32;
    localparam int PKG_ERR_W   = 16;
    localparam int PKG_MAG_W   = 16;
    localparam int PKG_CLAMP_W = 16;
    localparam int PKG_INT_W   = 24;
    localparam int PKG_P_SH    = 2;
    localparam int PKG_I_SH    = 6;
    localparam int PKG_LOCK_N  = 16;

    // Per-cycle action of the trim loop
    typedef enum logic [1:0] {
        MD_NOMINAL = 2'd0,  // current too low: hold nominal, clear loop state
        MD_HOLD    = 2'd1,  // tracking, no new estimate
        MD_TRIM    = 2'd2   // tracking, apply one loop update
    } trim_mode_e;
endpackage

// File: rtl/sclk_nco.sv
module sclk_nco
    import sclk_pkg::*;
#(
    parameter int ACC_W  = PKG_ACC_W,
    parameter int STEP_W = PKG_CLAMP_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  trim_mode_e               mode,
    input  logic [ACC_W-1:0]         nom_inc,
    input  logic signed [STEP_W-1:0] step,
    output logic [ACC_W-1:0]         inc_q,
    output logic [ACC_W-1:0]         acc_q,
    output logic                     strobe_q
);
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] step_x;

    always_comb begin
        sum    = {1'b0, acc_q} + {1'b0, inc_q};
        step_x = {{(ACC_W-STEP_W){step[STEP_W-1]}}, step};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            strobe_q <= 1'b0;
            inc_q    <= nom_inc;
        end else begin
            acc_q    <= sum[ACC_W-1:0];
            strobe_q <= sum[ACC_W];
            case (mode)
                MD_NOMINAL: inc_q <= nom_inc;
                MD_TRIM:    inc_q <= inc_q + step_x;
                default:    inc_q <= inc_q;
            endcase
        end
    end
endmodule

// File: rtl/sclk_loop_filter.sv
module sclk_loop_filter
    import sclk_pkg::*;
#(
    parameter int ERR_W   = PKG_ERR_W,
    parameter int CLAMP_W = PKG_CLAMP_W,
    parameter int INT_W   = PKG_INT_W,
    parameter int P_SH    = PKG_P_SH,
    parameter int I_SH    = PKG_I_SH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  trim_mode_e                mode,
    input  logic signed [ERR_W-1:0]   freq_err,
    input  logic signed [ERR_W-1:0]   ph_err,
    input  logic [CLAMP_W-1:0]        step_clamp,
    output logic signed [CLAMP_W:0]   step
);
    localparam int E_W = ERR_W + 1;
    localparam int S_W = INT_W + 1;
    localparam int C_W = INT_W + 2;

    logic signed [E_W-1:0]   err_sum;
    logic signed [S_W-1:0]   int_wide;
    logic signed [INT_W-1:0] int_q, int_nxt;
    logic signed [C_W-1:0]   e_x, i_x, corr, lim, nlim;

    always_comb begin
        err_sum  = {freq_err[ERR_W-1], freq_err} + {ph_err[ERR_W-1], ph_err};
        int_wide = {int_q[INT_W-1], int_q} + {{(S_W-E_W){err_sum[E_W-1]}}, err_sum};
        if (int_wide[S_W-1] != int_wide[S_W-2])
            int_nxt = int_wide[S_W-1] ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
        else
            int_nxt = int_wide[INT_W-1:0];

        e_x  = {{(C_W-E_W){err_sum[E_W-1]}}, err_sum};
        i_x  = {{(C_W-INT_W){int_nxt[INT_W-1]}}, int_nxt};
        corr = (e_x >>> P_SH) + (i_x >>> I_SH);
        lim  = {{(C_W-CLAMP_W){1'b0}}, step_clamp};
        nlim = -lim;
        if (corr > lim)
            step = lim[CLAMP_W:0];
        else if (corr < nlim)
            step = nlim[CLAMP_W:0];
        else
            step = corr[CLAMP_W:0];
    end

    always_ff @(posedge clk) begin
        if (rst || mode == MD_NOMINAL)
            int_q <= '0;
        else if (mode == MD_TRIM)
            int_q <= int_nxt;
    end
endmodule

// File: rtl/sclk_lock_det.sv
module sclk_lock_det
    import sclk_pkg::*;
#(
    parameter int ERR_W  = PKG_ERR_W,
    parameter int LOCK_N = PKG_LOCK_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  trim_mode_e              mode,
    input  logic signed [ERR_W-1:0] ph_err,
    input  logic [ERR_W-1:0]        lock_thr,
    output logic                    locked
);
    localparam int CNT_W = $clog2(LOCK_N + 1);

    logic [CNT_W-1:0] good_cnt;
    logic [ERR_W:0]   ph_mag;
    logic             in_bound;

    always_comb begin
        ph_mag   = ph_err[ERR_W-1] ? (-{1'b1, ph_err}) : {1'b0, ph_err};
        in_bound = ph_mag < {1'b0, lock_thr};
    end

    always_ff @(posedge clk) begin
        if (rst || mode == MD_NOMINAL) begin
            good_cnt <= '0;
            locked   <= 1'b0;
        end else if (mode == MD_TRIM) begin
            if (in_bound) begin
                if (good_cnt != CNT_W'(LOCK_N))
                    good_cnt <= good_cnt + 1'b1;
                locked <= (good_cnt >= CNT_W'(LOCK_N - 1));
            end else begin
                good_cnt <= '0;
                locked   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sclk_lock_ctrl.sv
module sclk_lock_ctrl
    import sclk_pkg::*;
#(
    parameter int ACC_W   = PKG_ACC_W,
    parameter int ERR_W   = PKG_ERR_W,
    parameter int MAG_W   = PKG_MAG_W,
    parameter int CLAMP_W = PKG_CLAMP_W,
    parameter int INT_W   = PKG_INT_W,
    parameter int P_SH    = PKG_P_SH,
    parameter int I_SH    = PKG_I_SH,
    parameter int LOCK_N  = PKG_LOCK_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_valid,
    input  logic signed [ERR_W-1:0] freq_err,
    input  logic signed [ERR_W-1:0] ph_err_chan,
    input  logic signed [ERR_W-1:0] ph_err_phsr,
    input  logic                    use_phsr,
    input  logic [MAG_W-1:0]        cur_mag,
    input  logic [MAG_W-1:0]        cur_thresh,
    input  logic [ACC_W-1:0]        nom_inc,
    input  logic [CLAMP_W-1:0]      step_clamp,
    input  logic [ERR_W-1:0]        lock_thr,
    output logic                    sample_strobe,
    output logic [ACC_W-1:0]        cur_inc,
    output logic                    locked
);
    trim_mode_e              mode;
    logic signed [ERR_W-1:0] ph_sel;
    logic signed [CLAMP_W:0] step;
    logic [ACC_W-1:0]        acc_unused_q;

    always_comb begin
        if (!(cur_mag > cur_thresh)) mode = MD_NOMINAL;
        else if (upd_valid)          mode = MD_TRIM;
        else                         mode = MD_HOLD;
        ph_sel = use_phsr ? ph_err_phsr : ph_err_chan;
    end

    sclk_loop_filter #(
        .ERR_W(ERR_W), .CLAMP_W(CLAMP_W), .INT_W(INT_W), .P_SH(P_SH), .I_SH(I_SH)
    ) u_filt (
        .clk(clk), .rst(rst), .mode(mode), .freq_err(freq_err), .ph_err(ph_sel),
        .step_clamp(step_clamp), .step(step)
    );

    sclk_lock_det #(.ERR_W(ERR_W), .LOCK_N(LOCK_N)) u_lock (
        .clk(clk), .rst(rst), .mode(mode), .ph_err(ph_sel), .lock_thr(lock_thr),
        .locked(locked)
    );

    sclk_nco #(.ACC_W(ACC_W), .STEP_W(CLAMP_W + 1)) u_nco (
        .clk(clk), .rst(rst), .mode(mode), .nom_inc(nom_inc), .step(step),
        .inc_q(cur_inc), .acc_q(acc_unused_q), .strobe_q(sample_strobe)
    );
endmodule

// File: rtl/sclk_lock_chk.sv
module sclk_lock_chk #(
    parameter int ACC_W   = 32,
    parameter int ERR_W   = 16,
    parameter int MAG_W   = 16,
    parameter int CLAMP_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    upd_valid,
    input logic signed [ERR_W-1:0] ph_err_chan,
    input logic signed [ERR_W-1:0] ph_err_phsr,
    input logic                    use_phsr,
    input logic [MAG_W-1:0]        cur_mag,
    input logic [MAG_W-1:0]        cur_thresh,
    input logic [ACC_W-1:0]        nom_inc,
    input logic [CLAMP_W-1:0]      step_clamp,
    input logic [ERR_W-1:0]        lock_thr,
    input logic                    sample_strobe,
    input logic [ACC_W-1:0]        cur_inc,
    input logic                    locked,
    input logic [ACC_W-1:0]        acc
);
    logic          trk;
    logic [ERR_W:0] ph_abs;
    logic signed [ERR_W-1:0] ph_pick;

    always_comb begin
        trk     = cur_mag > cur_thresh;
        ph_pick = use_phsr ? ph_err_phsr : ph_err_chan;
        ph_abs  = ph_pick[ERR_W-1] ? (-{1'b1, ph_pick}) : {1'b0, ph_pick};
    end

    AST_RESET_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_inc == $past(nom_inc) && !locked && !sample_strobe)); // R1

    AST_STROBE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        sample_strobe == (acc < $past(acc))); // R2

    AST_FALLBACK_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        !trk |=> (cur_inc == $past(nom_inc) && !locked)); // R3

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (trk && upd_valid) |=>
            (($signed(cur_inc - $past(cur_inc)) <= $signed({1'b0, $past(step_clamp)})) &&
             ($signed(cur_inc - $past(cur_inc)) >= -$signed({1'b0, $past(step_clamp)})))); // R6

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
        (trk && upd_valid && ph_abs >= {1'b0, lock_thr}) |=> !locked); // R8

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (trk && !upd_valid) |=> ($stable(cur_inc) && $stable(locked))); // R9
endmodule

bind sclk_lock_ctrl sclk_lock_chk #(
    .ACC_W(ACC_W), .ERR_W(ERR_W), .MAG_W(MAG_W), .CLAMP_W(CLAMP_W)
) u_chk (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .ph_err_chan(ph_err_chan),
    .ph_err_phsr(ph_err_phsr), .use_phsr(use_phsr), .cur_mag(cur_mag),
    .cur_thresh(cur_thresh), .nom_inc(nom_inc), .step_clamp(step_clamp),
    .lock_thr(lock_thr), .sample_strobe(sample_strobe), .cur_inc(cur_inc),
    .locked(locked), .acc(u_nco.acc_q)
);

// File: tb/sim_sclk_lock_ctrl.sv
`timescale 1ns/1ps
module sim_sclk_lock_ctrl;
    logic               clk = 1'b0;
    logic               rst;
    logic               upd_valid;
    logic signed [15:0] freq_err, ph_err_chan, ph_err_phsr;
    logic               use_phsr;
    logic [15:0]        cur_mag, cur_thresh, step_clamp, lock_thr;
    logic [31:0]        nom_inc;
    logic               sample_strobe, locked;
    logic [31:0]        cur_inc;

    always #2.5 clk = ~clk;

    sclk_lock_ctrl #(
        .ACC_W(32), .ERR_W(16), .MAG_W(16), .CLAMP_W(16),
        .INT_W(24), .P_SH(2), .I_SH(6), .LOCK_N(16)
    ) u0 (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .freq_err(freq_err),
        .ph_err_chan(ph_err_chan), .ph_err_phsr(ph_err_phsr), .use_phsr(use_phsr),
        .cur_mag(cur_mag), .cur_thresh(cur_thresh), .nom_inc(nom_inc),
        .step_clamp(step_clamp), .lock_thr(lock_thr), .sample_strobe(sample_strobe),
        .cur_inc(cur_inc), .locked(locked)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    started = 0;
    bit    done = 0;
    string inc_req = "R1";
    string lock_req = "R1";

    // behavioural reference model
    longint m_acc, m_inc, m_integ;
    int     m_cnt;
    bit     m_lock, m_strb;

    always @(posedge clk) begin
        longint s, ph, e, corr, lim, aph;
        started = 1;
        if (rst) begin
            m_acc = 0; m_inc = nom_inc; m_integ = 0; m_cnt = 0; m_lock = 0; m_strb = 0;
        end else begin
            s      = m_acc + m_inc;
            m_strb = (s >= 64'sd4294967296);
            m_acc  = s & 64'hFFFF_FFFF;
            if (!(cur_mag > cur_thresh)) begin
                m_inc = nom_inc; m_integ = 0; m_cnt = 0; m_lock = 0;
            end else if (upd_valid) begin
                ph = use_phsr ? longint'(ph_err_phsr) : longint'(ph_err_chan);
                e  = longint'(freq_err) + ph;
                m_integ = m_integ + e;
                if (m_integ > 8388607)  m_integ = 8388607;
                if (m_integ < -8388608) m_integ = -8388608;
                corr = (e >>> 2) + (m_integ >>> 6);
                lim  = step_clamp;
                if (corr > lim)  corr = lim;
                if (corr < -lim) corr = -lim;
                m_inc = (m_inc + corr) & 64'hFFFF_FFFF;
                aph = (ph < 0) ? -ph : ph;
                if (aph < longint'(lock_thr)) begin
                    if (m_cnt < 16) m_cnt++;
                    m_lock = (m_cnt >= 16);
                end else begin
                    m_cnt = 0; m_lock = 0;
                end
            end
        end
    end

    // compare away from the active edge, every cycle
    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (cur_inc !== 32'(m_inc)) begin
                n_bad++;
                $display("FAIL %s cur_inc actual=%h expected=%h t=%0t", inc_req, cur_inc, 32'(m_inc), $time);
            end
            n_cmp++;
            if (sample_strobe !== m_strb) begin
                n_bad++;
                $display("FAIL R2 sample_strobe actual=%0b expected=%0b t=%0t", sample_strobe, m_strb, $time);
            end
            n_cmp++;
            if (locked !== m_lock) begin
                n_bad++;
                $display("FAIL %s locked actual=%0b expected=%0b t=%0t", lock_req, locked, m_lock, $time);
            end
        end
    end

    task automatic updates(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            upd_valid = 1'b1;
            @(negedge clk);
            upd_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    initial begin
        rst = 1'b1; upd_valid = 1'b0; use_phsr = 1'b0;
        freq_err = 0; ph_err_chan = 0; ph_err_phsr = 0;
        cur_mag = 16'd10; cur_thresh = 16'd100; nom_inc = 32'h1000_0000;
        step_clamp = 16'd64; lock_thr = 16'd100;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R3: low current, updates with large errors must not move the clock
        inc_req = "R3"; lock_req = "R3";
        freq_err = 16'sd4000; ph_err_chan = 16'sd3000; ph_err_phsr = 16'sd10;
        updates(10, 3);
        cur_mag = 16'd100; // equal to threshold: still no tracking
        updates(5, 2);

        // R4/R6: tracking on channel estimate, corrections hit the clamp
        cur_mag = 16'd500; inc_req = "R4"; lock_req = "R8";
        freq_err = 16'sd300; ph_err_chan = 16'sd200; ph_err_phsr = -16'sd3000;
        updates(20, 3);

        // R5: switch to phasor estimate, in-bound phase error builds lock (R7)
        inc_req = "R5"; lock_req = "R7";
        use_phsr = 1'b1; freq_err = 16'sd0; ph_err_phsr = 16'sd50; ph_err_chan = 16'sd5000;
        step_clamp = 16'd2000;
        updates(20, 2);
        ph_err_phsr = -16'sd99;
        updates(3, 1);

        // R9: no update strobe, errors swing widely
        inc_req = "R9"; lock_req = "R9";
        for (int i = 0; i < 30; i++) begin
            freq_err = 16'(i * 977); ph_err_phsr = 16'(i * -1311);
            @(negedge clk);
        end

        // R8: one out-of-bound update drops lock
        inc_req = "R8"; lock_req = "R8";
        freq_err = 16'sd0; ph_err_phsr = 16'sd100;
        updates(1, 3);
        ph_err_phsr = 16'sd20;
        updates(5, 1);

        // R6: negative errors, wide clamp, then narrow clamp
        inc_req = "R6"; lock_req = "R8"; use_phsr = 1'b0;
        freq_err = -16'sd9000; ph_err_chan = -16'sd7000;
        updates(10, 2);
        step_clamp = 16'd5;
        updates(6, 2);
        step_clamp = 16'd0;
        updates(3, 1);

        // R3: current falls away: back to nominal
        inc_req = "R3"; lock_req = "R3";
        cur_mag = 16'd20;
        updates(4, 4);
        cur_mag = 16'd500; inc_req = "R4"; lock_req = "R7";
        freq_err = 16'sd10; ph_err_chan = 16'sd3; step_clamp = 16'd64;
        updates(18, 1);

        // R1: reset mid-run
        inc_req = "R1"; lock_req = "R1";
        rst = 1'b1; nom_inc = 32'h0C00_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule